// File: doc/BRIEF.md
# LIN Bus Wake-up Detector

This block watches the received LIN bus level while the device sits in a low-power state, with its transmitter off and only the receiver alive. It recognises a wake-up request from the bus as a dominant (low) level held for at least a programmable number of system clocks, followed by a return to recessive. A dominant pulse that ends too early is discarded, and the count starts again from zero on the next dominant level.

What a recognised wake-up does depends on the low-power state. In Stop it raises a wake interrupt. In Sleep it raises a system reset request. Both cases set a wake-source flag that software reads back and clears. The detector is armed when the device enters a low-power state. It stays idle in Normal mode, and it stays idle for the whole low-power stay when the receive-only bit was set at entry.

Top module: `lin_wake_detector`

## Requirements
- R1: After reset `wake_flag`, `wake_irq` and `rst_req` are all 0.
- R2: With the detector armed, a bus level `rx_level`=0 (dominant) sampled on at least `FILT_CYCLES` consecutive clock edges, followed by a sample of `rx_level`=1, is a wake-up. `wake_flag` rises on the clock edge that takes the first recessive sample.
- R3: A dominant run of `FILT_CYCLES`-1 samples followed by recessive is no wake-up. Short runs do not add up, so two such runs in a row also give no wake-up.
- R4: In Stop mode (`mode_sel`=2'b01) a wake-up sets `wake_flag` and `wake_irq` on the same edge. `rst_req` stays 0.
- R5: In Sleep mode (`mode_sel`=2'b10) a wake-up sets `wake_flag` and `rst_req`, and `wake_irq` stays 0. `rst_req` then holds until `rst_n` is asserted. `src_rd` has no effect on it.
- R6: In Normal mode (`mode_sel`=2'b00) and in the reserved code 2'b11 the detector is idle. No bus pattern changes any output.
- R7: `rx_only` is sampled on the clock edge that moves the mode from a non-low-power code into Stop or Sleep. If it is 1 there, no wake-up is recognised until the device next leaves low power. A change from Stop to Sleep or back is not a new entry.
- R8: A `src_rd` pulse clears `wake_flag` on the next edge. If a wake-up happens on the same edge, the flag stays set.
- R9: `wake_irq` falls one clock edge after `wake_flag` falls, unless a new Stop wake-up occurs on that edge.
- R10: A dominant level held far beyond `FILT_CYCLES` gives no wake-up until the bus returns to recessive. The detector stays armed after a wake-up and recognises the next valid pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | 1 | Synchronised receiver level, 0 = dominant, 1 = recessive |
| mode_sel | input | 2 | 00 Normal, 01 Stop, 10 Sleep, 11 reserved (treated as Normal) |
| rx_only | input | 1 | Receive-only control bit |
| src_rd | input | 1 | One-cycle strobe: interrupt-source register is being read |
| wake_irq | output | 1 | Wake-up interrupt (Stop mode) |
| rst_req | output | 1 | System reset request (Sleep mode) |
| wake_flag | output | 1 | Wake-source flag of the interrupt-source register |

## Verification
The assertions assume that `rx_level` has already been synchronised to `clk` and changes only between edges. They also assume that `mode_sel` holds one value for many cycles, so that the armed state has settled before a bus pattern is judged. The bench drives every input on the falling clock edge. It changes the mode at least one cycle before the first dominant sample, and it gives `src_rd` as a single-cycle pulse. The only case where inputs coincide on purpose is the read strobe landing on the edge that takes the recessive sample, which is how the set-over-clear priority is tested.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;

   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_STOP   = 2'b01,
      MODE_SLEEP  = 2'b10,
      MODE_RSVD   = 2'b11
   } lw_mode_e;

   function automatic logic lw_is_low_power(input lw_mode_e m);
      return (m == MODE_STOP) || (m == MODE_SLEEP);
   endfunction

   function automatic int lw_cnt_width(input int limit);
      return (limit < 2) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/lin_wake_arm.sv
module lin_wake_arm
   import lin_wake_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  lw_mode_e mode,
   input  logic     rx_only,
   output logic     armed
);

   logic lp_now;
   logic lp_prev_q;
   logic entry;
   logic armed_q;
   logic armed_d;

   assign lp_now = lw_is_low_power(mode);
   assign entry  = lp_now && !lp_prev_q;

   always_comb begin
      armed_d = 1'b0;
      if (lp_now) begin
         if (entry) armed_d = !rx_only;
         else       armed_d = armed_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lp_prev_q <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         lp_prev_q <= lp_now;
         armed_q   <= armed_d;
      end
   end

   assign armed = armed_q;

   AST_IDLE_OUTSIDE_LP: assert property (@(posedge clk) disable iff (!rst_n)
      !lw_is_low_power(mode) |=> !armed) else $error("armed outside low power"); // R6
   AST_RXONLY_AT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (entry && rx_only) |=> !armed) else $error("armed despite rx_only"); // R7

endmodule

// File: rtl/lin_wake_filter.sv
module lin_wake_filter #(
   parameter int FILT_CYCLES = 40,
   parameter int CW          = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic rx_level,
   output logic evt
);

   localparam logic [CW-1:0] LIMIT = CW'(FILT_CYCLES);

   logic [CW-1:0] dom_cnt_q;
   logic          qualified;

   assign qualified = (dom_cnt_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dom_cnt_q <= '0;
      end else if (!armed || rx_level) begin
         dom_cnt_q <= '0;
      end else if (!qualified) begin
         dom_cnt_q <= dom_cnt_q + 1'b1;
      end
   end

   assign evt = armed && rx_level && qualified;

   AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      evt |-> (rx_level && $past(!rx_level))) else $error("wake event without rising edge"); // R2

endmodule

// File: rtl/lin_wake_report.sv
module lin_wake_report
   import lin_wake_pkg::*;
#(
   parameter bit RST_PULSE = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     evt,
   input  lw_mode_e mode,
   input  logic     src_rd,
   output logic     wake_flag,
   output logic     wake_irq,
   output logic     rst_req
);

   logic evt_stop;
   logic evt_sleep;
   logic flag_q;
   logic irq_q;
   logic rst_q;

   assign evt_stop  = evt && (mode == MODE_STOP);
   assign evt_sleep = evt && (mode == MODE_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (evt_stop || evt_sleep) flag_q <= 1'b1;
         else if (src_rd)           flag_q <= 1'b0;
         irq_q <= evt_stop || (irq_q && flag_q);
      end
   end

   generate
      if (RST_PULSE) begin : g_rst_pulse
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= evt_sleep;
         end
      end else begin : g_rst_hold
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rst_q <= 1'b0;
            else        rst_q <= rst_q || evt_sleep;
         end
         AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            rst_q |=> rst_q) else $error("reset request dropped"); // R5
      end
   endgenerate

   assign wake_flag = flag_q;
   assign wake_irq  = irq_q;
   assign rst_req   = rst_q;

   AST_IRQ_ONLY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_irq) |-> $past(mode == MODE_STOP)) else $error("irq outside stop"); // R4
   AST_RST_ONLY_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> $past(mode == MODE_SLEEP)) else $error("reset request outside sleep"); // R5
   AST_FLAG_FROM_EVT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_flag) |-> $past(evt)) else $error("flag set without event"); // R2
   AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_flag && src_rd && !evt) |=> !wake_flag) else $error("read did not clear flag"); // R8
   AST_IRQ_TRAILS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_irq && !wake_flag && !evt) |=> !wake_irq) else $error("irq outlived flag"); // R9

endmodule

// File: rtl/lin_wake_detector.sv
module lin_wake_detector
   import lin_wake_pkg::*;
#(
   parameter int FILT_CYCLES = 40,
   parameter bit RST_PULSE   = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_level,
   input  logic [1:0] mode_sel,
   input  logic       rx_only,
   input  logic       src_rd,
   output logic       wake_irq,
   output logic       rst_req,
   output logic       wake_flag
);

   localparam int CW = lw_cnt_width(FILT_CYCLES);

   generate
      if (FILT_CYCLES < 1) begin : g_bad_filt
         $error("FILT_CYCLES must be at least 1");
      end
   endgenerate

   lw_mode_e mode;
   logic     armed;
   logic     evt;

   assign mode = lw_mode_e'(mode_sel);

   lin_wake_arm u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .rx_only (rx_only),
      .armed   (armed)
   );

   lin_wake_filter #(
      .FILT_CYCLES (FILT_CYCLES),
      .CW          (CW)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .armed    (armed),
      .rx_level (rx_level),
      .evt      (evt)
   );

   lin_wake_report #(
      .RST_PULSE (RST_PULSE)
   ) u_report (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt       (evt),
      .mode      (mode),
      .src_rd    (src_rd),
      .wake_flag (wake_flag),
      .wake_irq  (wake_irq),
      .rst_req   (rst_req)
   );

endmodule

// File: tb/sim_lin_wake_detector.sv
module sim_lin_wake_detector;

   localparam int FILT = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_level = 1'b1;
   logic [1:0] mode_sel = 2'b00;
   logic       rx_only = 1'b0;
   logic       src_rd = 1'b0;
   logic       wake_irq;
   logic       rst_req;
   logic       wake_flag;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   lin_wake_detector #(.FILT_CYCLES(FILT)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .rx_level  (rx_level),
      .mode_sel  (mode_sel),
      .rx_only   (rx_only),
      .src_rd    (src_rd),
      .wake_irq  (wake_irq),
      .rst_req   (rst_req),
      .wake_flag (wake_flag)
   );

   task automatic chk(input string req, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; rx_level = 1'b1; mode_sel = 2'b00; rx_only = 1'b0; src_rd = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic enter(input logic [1:0] m, input logic ro);
      mode_sel = m; rx_only = ro;
      @(negedge clk);
   endtask

   // dominant for n samples, then recessive; returns after the recessive edge
   task automatic pattern(input int n);
      rx_level = 1'b0;
      repeat (n) @(negedge clk);
      rx_level = 1'b1;
      @(negedge clk);
   endtask

   task automatic read_src();
      src_rd = 1'b1;
      @(negedge clk);
      src_rd = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1", "wake_flag", wake_flag, 1'b0);
      chk("R1", "wake_irq", wake_irq, 1'b0);
      chk("R1", "rst_req", rst_req, 1'b0);
   endtask

   task automatic t_normal();
      do_reset();
      enter(2'b00, 1'b0);
      pattern(3 * FILT);
      chk("R6", "normal flag", wake_flag, 1'b0);
      chk("R6", "normal irq", wake_irq, 1'b0);
      chk("R6", "normal rst", rst_req, 1'b0);
      enter(2'b11, 1'b0);
      pattern(3 * FILT);
      chk("R6", "reserved flag", wake_flag, 1'b0);
      chk("R6", "reserved irq", wake_irq, 1'b0);
      chk("R6", "reserved rst", rst_req, 1'b0);
   endtask

   task automatic t_stop_valid();
      do_reset();
      enter(2'b01, 1'b0);
      pattern(FILT);
      chk("R2", "flag after exact filter", wake_flag, 1'b1);
      chk("R4", "stop irq", wake_irq, 1'b1);
      chk("R4", "stop no rst", rst_req, 1'b0);
      read_src();
      chk("R8", "flag cleared by read", wake_flag, 1'b0);
      chk("R9", "irq one cycle longer", wake_irq, 1'b1);
      @(negedge clk);
      chk("R9", "irq dropped", wake_irq, 1'b0);
   endtask

   task automatic t_short();
      do_reset();
      enter(2'b01, 1'b0);
      pattern(FILT - 1);
      chk("R3", "short pulse", wake_flag, 1'b0);
      pattern(FILT - 1);
      chk("R3", "no accumulation", wake_flag, 1'b0);
      chk("R3", "no irq", wake_irq, 1'b0);
      pattern(FILT);
      chk("R2", "valid after shorts", wake_flag, 1'b1);
   endtask

   task automatic t_long();
      do_reset();
      enter(2'b01, 1'b0);
      rx_level = 1'b0;
      repeat (3 * FILT) @(negedge clk);
      chk("R10", "no wake while dominant", wake_flag, 1'b0);
      rx_level = 1'b1;
      @(negedge clk);
      chk("R10", "wake at release", wake_flag, 1'b1);
      read_src();
      @(negedge clk);
      chk("R10", "irq gone before rearm", wake_irq, 1'b0);
      pattern(FILT + 5);
      chk("R10", "second wake flag", wake_flag, 1'b1);
      chk("R10", "second wake irq", wake_irq, 1'b1);
   endtask

   task automatic t_sleep();
      do_reset();
      enter(2'b10, 1'b0);
      pattern(FILT);
      chk("R5", "sleep rst", rst_req, 1'b1);
      chk("R5", "sleep flag", wake_flag, 1'b1);
      chk("R5", "sleep no irq", wake_irq, 1'b0);
      read_src();
      chk("R8", "sleep flag cleared", wake_flag, 1'b0);
      repeat (3) @(negedge clk);
      chk("R5", "rst held after read", rst_req, 1'b1);
      do_reset();
      chk("R5", "rst cleared by reset", rst_req, 1'b0);
   endtask

   task automatic t_rxonly();
      do_reset();
      enter(2'b01, 1'b1);
      rx_only = 1'b0;
      @(negedge clk);
      pattern(FILT + 2);
      chk("R7", "stop with rx_only", wake_flag, 1'b0);
      enter(2'b10, 1'b0);
      @(negedge clk);
      pattern(FILT + 2);
      chk("R7", "switch to sleep not entry flag", wake_flag, 1'b0);
      chk("R7", "switch to sleep not entry rst", rst_req, 1'b0);
      enter(2'b00, 1'b0);
      enter(2'b01, 1'b0);
      pattern(FILT);
      chk("R7", "re-entry arms", wake_flag, 1'b1);
   endtask

   task automatic t_collide();
      do_reset();
      enter(2'b01, 1'b0);
      pattern(FILT);
      chk("R4", "first wake", wake_flag, 1'b1);
      rx_level = 1'b0;
      repeat (FILT) @(negedge clk);
      rx_level = 1'b1;
      src_rd = 1'b1;
      @(negedge clk);
      src_rd = 1'b0;
      chk("R8", "event wins over read", wake_flag, 1'b1);
      chk("R9", "irq kept by new event", wake_irq, 1'b1);
   endtask

   initial begin
      t_reset();
      t_normal();
      t_stop_valid();
      t_short();
      t_long();
      t_sleep();
      t_rxonly();
      t_collide();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule